// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit up-counter driven by a two-stage clock divider. The first stage passes either every system clock cycle or one cycle in sixteen. The second stage divides that again by a programmable 8-bit value plus one. Each divided tick advances the counter. When a tick finds the counter equal to the reference value, the block sets a sticky reference flag. It can then restart the count from zero, and it can drive a level interrupt for as long as the flag stays set.

Software reaches the block through a plain byte-addressed register port. A write is taken on the rising clock edge whenever `bus_wr` is high. There is no handshake and no back-pressure: every write completes in that one cycle. Read data is a combinational function of `bus_addr`, so a read needs no strobe. Because no data stream flows in or out, no valid/ready pair is used. The register map is as follows. Offset 0x0 holds the mode word, 0x4 the reference, 0x8 a general capture word, 0xC the live counter, and 0x11 the event flags.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Mode bit 0 is the enable. While it is 0 the counter holds its value. A mode write that finds bit 0 set and writes it as 0 leaves both the mode word and the reference reading 0. A mode write with bit 0 already clear stores the written value.
- R3: With clock-select bits [2:1] = 1, the counter advances once every P+1 clock cycles, where P is mode bits [15:8]. The first advance comes P+1 edges after the enabling write.
- R4: With clock-select = 2, the counter advances once every 16·(P+1) clock cycles.
- R5: Clock-select values 0 and 3 leave the counter stopped even with the enable set.
- R6: On a tick where the counter equals the reference, event bit 1 is set. With restart (mode bit 3) set, the counter becomes 0 on that tick. With restart clear, it goes on to reference+1.
- R7: `irq_o` is high exactly when mode bit 4 and event bit 1 are both 1.
- R8: A write to the event offset clears each event bit written as 1 and leaves each bit written as 0. A flag being set on the same edge wins over the clear.
- R9: A write to the counter offset loads the counter on that edge, overriding a tick, and 16-bit counting wraps from 0xFFFF to 0.
- R10: The capture word is read/write storage. Reads of unmapped offsets return 0, and writes there change no register.
- R11: Any write to the mode or reference offset restarts the divider phase, so the next tick is a full P+1 (or 16·(P+1)) cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 5 | Byte offset for both writes and reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt: reference flag gated by its enable |

## Verification
A register write lands on the edge that samples it, so its effect is visible half a cycle later. The bench drives every input just after a falling edge and samples at the following falling edge. The counter advances on the edge that ends the (P+1)-th selected-clock period after the last mode or reference write, so the bench checks the count one cycle before and one cycle after each expected tick. The reference flag and the interrupt follow on the same edge as the matching tick. They are checked at the sample point right after that edge, together with the wrapped counter value.

// File: rtl/refcmp_pkg.sv
`timescale 1ns/1ps
package refcmp_pkg;
  // register offsets (byte addresses)
  localparam int OFS_MODE = 'h00;
  localparam int OFS_REF  = 'h04;
  localparam int OFS_CAPT = 'h08;
  localparam int OFS_CNT  = 'h0C;
  localparam int OFS_EVT  = 'h11;

  // mode word fields
  localparam int MB_EN      = 0;
  localparam int MB_CS_LSB  = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_REFIRQ  = 4;
  localparam int MB_PSC_LSB = 8;

  // event flags
  localparam int EV_CAPT = 0;
  localparam int EV_REF  = 1;
  localparam int EV_W    = 2;

  typedef enum logic [1:0] {
    CS_NONE  = 2'd0,
    CS_SYS   = 2'd1,
    CS_SYS16 = 2'd2,
    CS_RSVD  = 2'd3
  } clk_sel_e;
endpackage

// File: rtl/refcmp_prescaler.sv
`timescale 1ns/1ps
module refcmp_prescaler #(
  parameter int PSC_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             slow_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [PSC_W-1:0] pcnt_q;
  logic             src_en;
  logic             wrap;

  assign src_en = slow_i ? (div_q == DIV_MAX) : 1'b1;
  assign wrap   = (pcnt_q == psc_i);
  assign tick_o = run_i && !clr_i && src_en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else if (clr_i || !run_i) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (slow_i) div_q <= (div_q == DIV_MAX) ? '0 : div_q + DIV_W'(1);
      else        div_q <= '0;
      if (src_en) pcnt_q <= wrap ? '0 : pcnt_q + PSC_W'(1);
    end
  end

  // R3: undivided clock with P = 0 ticks on every cycle of a steady run
  a_r3_fast_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !slow_i && psc_i == '0 && !clr_i) |-> tick_o);
endmodule

// File: rtl/refcmp_counter.sv
`timescale 1ns/1ps
module refcmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = tick_i && !load_i && (cnt_q == ref_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (hit_o && restart_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + CNT_W'(1);
  end

  // R6: a matching tick with restart returns the count to zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q == ref_i && restart_i) |=> (cnt_o == '0));

  // R9: a counter write lands on the next edge
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/refcmp_regs.sv
`timescale 1ns/1ps
module refcmp_regs
  import refcmp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output clk_sel_e          cs_o,
  output logic              restart_o,
  output logic              refirq_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [DATA_W-1:0] ref_o,
  output logic [EV_W-1:0]   ev_o,
  output logic              cfg_wr_o,
  output logic              cnt_ld_o
);
  logic [DATA_W-1:0] mode_q, ref_q, capt_q;
  logic [EV_W-1:0]   ev_q;
  logic              sel_mode, sel_ref, sel_capt, sel_cnt, sel_ev;
  logic              disarm;
  logic [EV_W-1:0]   ev_clr, ev_set;

  assign sel_mode = wr_i && (addr_i == ADDR_W'(OFS_MODE));
  assign sel_ref  = wr_i && (addr_i == ADDR_W'(OFS_REF));
  assign sel_capt = wr_i && (addr_i == ADDR_W'(OFS_CAPT));
  assign sel_cnt  = wr_i && (addr_i == ADDR_W'(OFS_CNT));
  assign sel_ev   = wr_i && (addr_i == ADDR_W'(OFS_EVT));
  assign disarm   = sel_mode && mode_q[MB_EN] && !wdata_i[MB_EN];

  assign ev_clr = sel_ev ? wdata_i[EV_W-1:0] : '0;
  assign ev_set = EV_W'({hit_i, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      capt_q <= '0;
      ev_q   <= '0;
    end else begin
      if (disarm) begin
        mode_q <= '0;
        ref_q  <= '0;
      end else begin
        if (sel_mode) mode_q <= wdata_i;
        if (sel_ref)  ref_q  <= wdata_i;
      end
      if (sel_capt) capt_q <= wdata_i;
      ev_q <= (ev_q & ~ev_clr) | ev_set;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_MODE): rdata_o = mode_q;
      ADDR_W'(OFS_REF):  rdata_o = ref_q;
      ADDR_W'(OFS_CAPT): rdata_o = capt_q;
      ADDR_W'(OFS_CNT):  rdata_o = cnt_i;
      ADDR_W'(OFS_EVT):  rdata_o = DATA_W'(ev_q);
      default:           rdata_o = '0;
    endcase
  end

  assign en_o      = mode_q[MB_EN];
  assign cs_o      = clk_sel_e'(mode_q[MB_CS_LSB +: 2]);
  assign restart_o = mode_q[MB_RESTART];
  assign refirq_o  = mode_q[MB_REFIRQ];
  assign psc_o     = mode_q[MB_PSC_LSB +: PSC_W];
  assign ref_o     = ref_q;
  assign ev_o      = ev_q;
  assign cfg_wr_o  = sel_mode || sel_ref;
  assign cnt_ld_o  = sel_cnt;

  // R2: dropping the enable wipes the mode word and the reference
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADDR_W'(OFS_MODE) && en_o && !wdata_i[MB_EN])
      |=> (mode_q == '0 && ref_o == '0));

  // R6: the reference flag only rises after a matching tick
  a_r6_flag_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_o[EV_REF]) |-> $past(hit_i));

  // R8: writing one clears the flag unless a new hit arrives together
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADDR_W'(OFS_EVT) && wdata_i[EV_REF] && !hit_i)
      |=> !ev_o[EV_REF]);

  // R8: writing zero keeps a set flag
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o[EV_REF] && !(wr_i && addr_i == ADDR_W'(OFS_EVT) && wdata_i[EV_REF]))
      |=> ev_o[EV_REF]);
endmodule

// File: rtl/refcmp_timer.sv
`timescale 1ns/1ps
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic             en, restart, refirq, cfg_wr, cnt_ld, run, tick, hit;
  clk_sel_e         cs;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] ref_val, cnt;
  logic [EV_W-1:0]  ev;

  refcmp_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .cnt_i(cnt), .hit_i(hit), .rdata_o(bus_rdata),
    .en_o(en), .cs_o(cs), .restart_o(restart), .refirq_o(refirq),
    .psc_o(psc), .ref_o(ref_val), .ev_o(ev),
    .cfg_wr_o(cfg_wr), .cnt_ld_o(cnt_ld)
  );

  assign run = en && (cs == CS_SYS || cs == CS_SYS16);

  refcmp_prescaler #(.PSC_W(PSC_W), .SLOW_DIV(SLOW_DIV)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(cfg_wr),
    .slow_i(cs == CS_SYS16), .psc_i(psc), .tick_o(tick)
  );

  refcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(cnt_ld),
    .load_val_i(bus_wdata), .ref_i(ref_val), .restart_i(restart),
    .cnt_o(cnt), .hit_o(hit)
  );

  assign irq_o = refirq && ev[EV_REF];

  // R5: with no valid clock source and no counter write the count holds
  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));

  // R7: the interrupt rises only after a match or a configuration write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) || $past(cfg_wr)));
endmodule

// File: tb/test_refcmp_timer.sv
`timescale 1ns/1ps
module test_refcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAPT = 5'h08,
                         A_CNT = 5'h0C, A_EVT = 5'h11;

  always #5 clk = ~clk;

  refcmp_timer i_refcmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; commits on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_all();
    wr(A_MODE, 16'h0000);
    wr(A_EVT, 16'h0003);
  endtask

  task automatic t_reset();
    rchk("R1 mode", A_MODE, 16'h0);
    rchk("R1 ref", A_REF, 16'h0);
    rchk("R1 capt", A_CAPT, 16'h0);
    rchk("R1 cnt", A_CNT, 16'h0);
    rchk("R1 evt", A_EVT, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_fast();
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0100);
    wr(A_MODE, 16'h0003);
    rchk("R3 p0 start", A_CNT, 16'd0);
    idle(5);
    rchk("R3 p0 five cycles", A_CNT, 16'd5);
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0100);
    wr(A_MODE, 16'h0203);
    idle(8);
    rchk("R3 p2 before third", A_CNT, 16'd2);
    idle(1);
    rchk("R3 p2 third tick", A_CNT, 16'd3);
  endtask

  task automatic t_slow();
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0100);
    wr(A_MODE, 16'h0105);
    idle(31);
    rchk("R4 before first tick", A_CNT, 16'd0);
    idle(1);
    rchk("R4 first tick at 32", A_CNT, 16'd1);
    idle(32);
    rchk("R4 second tick at 64", A_CNT, 16'd2);
  endtask

  task automatic t_badsel();
    stop_all();
    wr(A_CNT, 16'h0007);
    wr(A_MODE, 16'h0001);
    idle(20);
    rchk("R5 select 0 holds", A_CNT, 16'h0007);
    wr(A_MODE, 16'h0007);
    idle(20);
    rchk("R5 select 3 holds", A_CNT, 16'h0007);
  endtask

  task automatic t_restart();
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0003);
    wr(A_MODE, 16'h000B);
    idle(3);
    rchk("R6 count reaches ref", A_CNT, 16'd3);
    rchk("R6 no flag yet", A_EVT, 16'h0);
    idle(1);
    rchk("R6 restart to zero", A_CNT, 16'd0);
    rchk("R6 flag set", A_EVT, 16'h2);
    chk("R7 irq low without enable", {15'b0, irq_o}, 16'h0);
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0002);
    wr(A_MODE, 16'h0003);
    idle(3);
    rchk("R6 no restart counts on", A_CNT, 16'd3);
    rchk("R6 flag without restart", A_EVT, 16'h2);
  endtask

  task automatic t_irq_evt();
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0002);
    wr(A_MODE, 16'h0013);
    idle(2);
    chk("R7 irq low before match", {15'b0, irq_o}, 16'h0);
    idle(1);
    chk("R7 irq on match", {15'b0, irq_o}, 16'h1);
    wr(A_MODE, 16'h0011);
    wr(A_MODE, 16'h0001);
    chk("R7 irq off with enable clear", {15'b0, irq_o}, 16'h0);
    rchk("R7 flag still set", A_EVT, 16'h2);
    wr(A_MODE, 16'h0011);
    chk("R7 irq back on", {15'b0, irq_o}, 16'h1);
    wr(A_EVT, 16'h0000);
    rchk("R8 zero write keeps", A_EVT, 16'h2);
    chk("R8 irq kept", {15'b0, irq_o}, 16'h1);
    wr(A_EVT, 16'h0001);
    rchk("R8 other bit write keeps", A_EVT, 16'h2);
    wr(A_EVT, 16'h0002);
    rchk("R8 one clears", A_EVT, 16'h0);
    chk("R8 irq drops", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_load();
    stop_all();
    wr(A_CNT, 16'h1234);
    rchk("R9 load while stopped", A_CNT, 16'h1234);
    wr(A_REF, 16'h0010);
    wr(A_MODE, 16'h0003);
    wr(A_CNT, 16'hFFFE);
    rchk("R9 load while running", A_CNT, 16'hFFFE);
    idle(1);
    rchk("R9 count after load", A_CNT, 16'hFFFF);
    idle(1);
    rchk("R9 wrap to zero", A_CNT, 16'h0000);
  endtask

  task automatic t_map();
    stop_all();
    wr(A_CNT, 16'h0055);
    wr(A_REF, 16'h0042);
    wr(A_CAPT, 16'hBEEF);
    rchk("R10 capture readback", A_CAPT, 16'hBEEF);
    rchk("R10 unmapped 0x14", 5'h14, 16'h0);
    rchk("R10 unmapped 0x10", 5'h10, 16'h0);
    wr(5'h18, 16'hFFFF);
    rchk("R10 stray write mode", A_MODE, 16'h0);
    rchk("R10 stray write ref", A_REF, 16'h0042);
    rchk("R10 stray write capt", A_CAPT, 16'hBEEF);
    rchk("R10 stray write cnt", A_CNT, 16'h0055);
    rchk("R10 stray write evt", A_EVT, 16'h0);
  endtask

  task automatic t_disarm();
    logic [15:0] a, b;
    stop_all();
    wr(A_MODE, 16'h0004);
    rchk("R2 store with enable already clear", A_MODE, 16'h0004);
    wr(A_REF, 16'h0055);
    wr(A_MODE, 16'h0F03);
    idle(3);
    wr(A_MODE, 16'h0F02);
    rchk("R2 mode cleared", A_MODE, 16'h0);
    rchk("R2 ref cleared", A_REF, 16'h0);
    rd(A_CNT, a);
    idle(40);
    rd(A_CNT, b);
    chk("R2 counter stopped", b, a);
  endtask

  task automatic t_phase();
    stop_all();
    wr(A_CNT, 16'h0);
    wr(A_REF, 16'h0100);
    wr(A_MODE, 16'h0403);
    idle(3);
    wr(A_REF, 16'h0100);
    idle(4);
    rchk("R11 phase restarted", A_CNT, 16'd0);
    idle(1);
    rchk("R11 tick after full period", A_CNT, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast();
    t_slow();
    t_badsel();
    t_restart();
    t_irq_evt();
    t_load();
    t_map();
    t_disarm();
    t_phase();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule